// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. It turns single read or write requests into the timed control waveforms the RAM needs. These are a low-active and a high-active chip select, a low-active write strobe and a low-active output enable. It also drives a 17-bit address and controls a shared 8-bit data bus through separate out and in paths plus a driver enable. Every analog minimum is turned into a whole number of clocks from the clock period and the speed grade. These minimums are access time, write pulse, data setup, output turn-off and cycle time.

The host side is a valid/ready request channel. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the host must hold its request fields stable until the handshake completes. Read data comes back on `rsp_valid`/`rsp_rdata` as a one-cycle pulse. The response channel has no back-pressure: the host must take the data in the cycle it is flagged. A write gives no response.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request pending, the RAM is deselected. That means `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0, with `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only on a clock with `req_valid`=1 and `req_ready`=1. `req_ready` stays 0 from the clock after acceptance until the operation has fully finished, and a request presented meanwhile is left waiting.
- R3: `mem_we_n` is 0 only while `mem_cs1_n`=0, `mem_cs2`=1 and `mem_oe_n`=1. `mem_addr` stays unchanged on every clock that the chip stays selected.
- R4: A write selects the chip for one setup cycle with the write strobe high. It then holds `mem_we_n` low for exactly WP cycles with `mem_dq_oe`=1 and `mem_dq_out` equal to the accepted write data.
- R5: A write ends when `mem_we_n` rises while both selects stay active. `mem_dq_oe` falls in that same clock. Selects stay active, with the strobe high, for REC cycles before the chip is deselected.
- R6: A read selects the chip with `mem_oe_n`=0 and `mem_we_n`=1 for exactly AA cycles. `mem_dq_in` is sampled on the edge that ends the last of these cycles.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: After a read, `mem_oe_n` stays high and the chip stays deselected for TURN cycles before the sequencer becomes idle. This keeps the bus undriven for at least DIS cycles after output enable rises. Consecutive operation starts are at least CYC cycles apart.
- R9: `rsp_valid` pulses for exactly one cycle, in the first cycle after a read's enable window closes, with `rsp_rdata` equal to the sampled byte. It never pulses for a write.
- R10: Each count is ceil(ns / CLK_NS) with a floor of one. FAST_GRADE=1 uses 55/45/25/20/55 ns for access/pulse/setup/turn-off/cycle, and FAST_GRADE=0 uses 70/50/30/25/70 ns. WP is the larger of the pulse and setup counts. REC = max(1, CYC-1-WP). TURN = max(1, DIS, CYC-AA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | RAM address |
| mem_cs1_n | output | 1 | RAM select, active low |
| mem_cs2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The assertions assume that the host holds its request fields stable while `req_valid` waits for `req_ready`. They also assume it never needs to stall a read response. The bench driver raises a request just after a clock edge and keeps it unchanged until it sees ready. It takes every response in the cycle it appears. The RAM model in the bench returns a poison byte until the access window has elapsed, so an early sample shows up at the read port. It records a byte only on a proper end of write and flags bus drive during output enable or too soon after it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_RACC,
    ST_RTRN
  } seq_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // the state loaded with N lasts N cycles; the final one shows cnt == 1
  assign last = (cnt_q <= CW'(1));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW     = 4,
  parameter int AA_C   = 7,
  parameter int WP_C   = 6,
  parameter int REC_C  = 1,
  parameter int TURN_C = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          tmr_last,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          idle,
  output logic          sel,
  output logic          we_low,
  output logic          oe_low,
  output logic          drive
);
  seq_state_t st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = CW'(1);
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (req_we) begin
          st_d = ST_WSET;
        end else begin
          st_d     = ST_RACC;
          tmr_load = 1'b1;
          tmr_val  = CW'(AA_C);
        end
      end
      ST_WSET: begin
        st_d     = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CW'(WP_C);
      end
      ST_WPUL: if (tmr_last) begin
        st_d     = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = CW'(REC_C);
      end
      ST_WREC: if (tmr_last) st_d = ST_IDLE;
      ST_RACC: if (tmr_last) begin
        st_d     = ST_RTRN;
        capture  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(TURN_C);
      end
      ST_RTRN: if (tmr_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // pin decode straight from the state register
  assign idle   = (st_q == ST_IDLE);
  assign sel    = (st_q == ST_WSET) || (st_q == ST_WPUL) ||
                  (st_q == ST_WREC) || (st_q == ST_RACC);
  assign we_low = (st_q == ST_WPUL);
  assign oe_low = (st_q == ST_RACC);
  assign drive  = (st_q == ST_WPUL);

  // R5: strobe rises only into the recovery state, selects still held
  p_we_rise_into_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_low) |-> (st_q == ST_WREC) && sel);
endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  // R9: one-cycle response pulse
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS     = 8,
  parameter int FAST_GRADE = 1,
  parameter int AW         = 17,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int T_AA  = FAST_GRADE ? 55 : 70;
  localparam int T_WP  = FAST_GRADE ? 45 : 50;
  localparam int T_DS  = FAST_GRADE ? 25 : 30;
  localparam int T_DIS = FAST_GRADE ? 20 : 25;
  localparam int T_CYC = FAST_GRADE ? 55 : 70;

  localparam int AA_C   = ns2cyc(T_AA, CLK_NS);
  localparam int WP_C   = imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DS, CLK_NS));
  localparam int DIS_C  = ns2cyc(T_DIS, CLK_NS);
  localparam int CYC_C  = ns2cyc(T_CYC, CLK_NS);
  localparam int REC_C  = imax(1, CYC_C - 1 - WP_C);
  localparam int TURN_C = imax(imax(1, DIS_C), CYC_C - AA_C);
  localparam int MAX_C  = imax(imax(AA_C, WP_C), imax(REC_C, TURN_C));
  localparam int CW     = $clog2(MAX_C + 1) + 1;

  logic          tmr_load, tmr_last, accept, capture, idle;
  logic          sel, we_low, oe_low, drive;
  logic [CW-1:0] tmr_val;

  sram_seq #(
    .CW(CW), .AA_C(AA_C), .WP_C(WP_C), .REC_C(REC_C), .TURN_C(TURN_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .idle(idle), .sel(sel),
    .we_low(we_low), .oe_low(oe_low), .drive(drive)
  );

  sram_wait_cnt #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .last(tmr_last)
  );

  sram_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  assign req_ready = idle;
  assign mem_cs1_n = ~sel;
  assign mem_cs2   = sel;
  assign mem_we_n  = ~we_low;
  assign mem_oe_n  = ~oe_low;
  assign mem_dq_oe = drive;

  // R3: strobe low only with both selects active and outputs off
  p_we_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs1_n && mem_cs2 && mem_oe_n);
  // R3: address frozen while the chip stays selected
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
  // R7: no bus drive while the RAM may be driving
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R5: strobe rises with selects held and drivers released, data held up to it
  p_we_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs1_n && mem_cs2 && !mem_dq_oe && $past(mem_dq_oe));
  // R1: idle means deselected and quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe);
  // R9: a response follows only a read enable window
  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n) && mem_oe_n);
endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int CLK_NS = 8;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  // R10: counts for the fast grade
  localparam int AA_C   = cyc(55);
  localparam int WP_C   = (cyc(45) > cyc(25)) ? cyc(45) : cyc(25);
  localparam int DIS_C  = cyc(20);
  localparam int CYC_C  = cyc(55);
  localparam int REC_C  = (CYC_C - 1 - WP_C > 1) ? CYC_C - 1 - WP_C : 1;
  localparam int TURN_C = (DIS_C > CYC_C - AA_C) ? DIS_C : ((CYC_C - AA_C > 1) ? CYC_C - AA_C : 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  always #4 clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .FAST_GRADE(1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram [int];
  int rd_age = 0, oe_hi_age = 100, since_start = 100, wlen = 0;
  bit prev_wlow = 0, prev_sel = 0, prev_drv = 0;
  logic [7:0] wbyte;
  logic [16:0] waddr;
  wire ram_sel = !mem_cs1_n && mem_cs2;
  wire [7:0] ram_byte = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  assign mem_dq_in = (ram_sel && mem_we_n && !mem_oe_n && rd_age >= AA_C) ? ram_byte : 8'hEE;

  always @(negedge clk) if (rst_n) begin
    if (ram_sel && mem_we_n && !mem_oe_n) rd_age <= rd_age + 1; else rd_age <= 0;
    if (ram_sel && !prev_sel) begin
      chk(since_start >= CYC_C, "R8", "op spacing", since_start, CYC_C);
      since_start <= 1;
    end else since_start <= since_start + 1;
    if (mem_dq_oe && !mem_oe_n) chk(0, "R7", "bus contention", 1, 0);
    if (mem_dq_oe && !prev_drv)
      chk(oe_hi_age >= DIS_C, "R8", "drive after oe high", oe_hi_age, DIS_C);
    oe_hi_age <= mem_oe_n ? oe_hi_age + 1 : 0;
    if (ram_sel && !mem_we_n) begin
      wlen  <= wlen + 1;
      wbyte <= mem_dq_out;
      waddr <= mem_addr;
      if (!mem_dq_oe) chk(0, "R4", "strobe low without data", 0, 1);
    end else begin
      wlen <= 0;
      if (prev_wlow) begin
        chk(wlen >= WP_C, "R4", "write pulse length", wlen, WP_C);
        ram[int'(waddr)] = wbyte;
      end
    end
    prev_wlow <= ram_sel && !mem_we_n;
    prev_sel  <= ram_sel;
    prev_drv  <= mem_dq_oe;
  end

  // ---------------- cycle reference model ----------------
  typedef struct packed {
    logic sel, we_low, oe_low, drv, rsp;
    logic [7:0] d;
    logic [16:0] a;
  } exp_t;
  exp_t q[$];
  logic [7:0] shadow [int];

  task automatic push(input logic s, w, o, dr, r, input logic [7:0] d, input logic [16:0] a);
    exp_t e;
    e.sel = s; e.we_low = w; e.oe_low = o; e.drv = dr; e.rsp = r; e.d = d; e.a = a;
    q.push_back(e);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (q.size() == 0) begin
      chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1", "idle pins", {req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid},
          7'b1101100);
    end else begin
      exp_t e;
      e = q.pop_front();
      chk(!req_ready, "R2", "ready while busy", req_ready, 0);
      chk({!mem_cs1_n, mem_cs2} == {e.sel, e.sel}, "R3", "selects", {!mem_cs1_n, mem_cs2}, {e.sel, e.sel});
      chk(!mem_we_n == e.we_low, "R4", "write strobe", !mem_we_n, e.we_low);
      chk(!mem_oe_n == e.oe_low, "R6", "output enable", !mem_oe_n, e.oe_low);
      chk(mem_dq_oe == e.drv, "R5", "bus drive", mem_dq_oe, e.drv);
      chk(rsp_valid == e.rsp, "R9", "rsp_valid", rsp_valid, e.rsp);
      if (e.sel) chk(mem_addr == e.a, "R3", "address", mem_addr, e.a);
      if (e.drv) chk(mem_dq_out == e.d, "R4", "write data", mem_dq_out, e.d);
      if (e.rsp) chk(rsp_rdata == e.d, "R6", "read data", rsp_rdata, e.d);
    end
    // a request seen now is taken at the next edge only if idle
    if (req_valid && req_ready && q.size() == 0) begin
      if (req_we) begin
        push(1, 0, 0, 0, 0, 0, req_addr);
        for (int i = 0; i < WP_C; i++) push(1, 1, 0, 1, 0, req_wdata, req_addr);
        for (int i = 0; i < REC_C; i++) push(1, 0, 0, 0, 0, 0, req_addr);
        shadow[int'(req_addr)] = req_wdata;
      end else begin
        logic [7:0] v;
        v = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00;
        for (int i = 0; i < AA_C; i++) push(1, 0, 1, 0, 0, 0, req_addr);
        for (int i = 0; i < TURN_C; i++) push(0, 0, 0, 0, i == 0, v, req_addr);
      end
    end
  end

  task automatic do_req(input bit we, input logic [16:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "reset pins", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);
    @(posedge clk); #1 rst_n = 1;
    // writes at the address extremes and assorted patterns (R4, R5, R10)
    do_req(1, 17'h00000, 8'h11);
    do_req(1, 17'h1FFFF, 8'hA5);
    do_req(1, 17'h0AAAA, 8'h3C);
    do_req(1, 17'h15555, 8'hFF);
    do_req(1, 17'h00100, 8'h00);
    // read-back (R6, R9); back-to-back requests wait on ready (R2)
    do_req(0, 17'h00000, 8'h00);
    do_req(0, 17'h1FFFF, 8'h00);
    do_req(0, 17'h0AAAA, 8'h00);
    do_req(0, 17'h15555, 8'h00);
    do_req(0, 17'h00100, 8'h00);
    do_req(0, 17'h12345, 8'h00);
    // read then write turnaround, overwrite and re-read (R7, R8)
    do_req(1, 17'h0AAAA, 8'h5A);
    do_req(0, 17'h0AAAA, 8'h00);
    do_req(1, 17'h0AAAA, 8'hC3);
    do_req(0, 17'h0AAAA, 8'h00);
    do_req(1, 17'h00001, 8'h81);
    do_req(0, 17'h00001, 8'h00);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2", "all operations completed", q.size(), 0);
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      finish_run();
    end
  end
endmodule